// File: doc/BRIEF.md
# Microprogram Sequencer for a Display-List Processor

This block is the control-store sequencer of a display-list processor. It holds a 512-word by 40-bit microcode ROM that is filled from an initialisation array given as a parameter. It also holds a 9-bit microprogram address register. When a display instruction arrives, its opcode selects the first microword of a routine. A host register access selects a routine in the same way, from its register address and a read/write flag. The sequencer then steps through the routine and emits one control word per cycle. Along the way it honours stall, branch, fetch and end-of-routine fields.

The controller has two states. In `SQ_IDLE` all control outputs are inactive and the block waits for work. A pending host access is taken first (transition *host dispatch*). Otherwise a valid instruction is taken (transition *instruction dispatch*). Both transitions lead to `SQ_RUN`. In `SQ_RUN` the current word is driven out. The block then moves by one of three transitions:
- *stall*: it stays in `SQ_RUN` at the same address.
- *advance*: it stays in `SQ_RUN` and goes to the next address or to a branch target.
- *finish*: it returns to `SQ_IDLE` after an end-of-routine word.

The ROM read is registered. A word therefore appears on `ctrl_word` in the cycle after the sequencer selects its address. That is the same cycle in which `upc_o` shows the address.

Top module: `ucode_sequencer`

## Requirements
- R1: After synchronous reset, `upc_o` is 0, the block is idle, and `ctrl_word`, `fetch_o`, `text_inc`, `instr_ack` and `host_ack` are all 0.
- R2: In idle with `instr_valid` high and `host_req` low, `instr_ack` is 1. On the next cycle `upc_o` equals 16 × `instr_opcode` and `ctrl_word` holds the ROM word at that address.
- R3: In idle with `host_req` high, `host_ack` is 1 and `instr_ack` is 0, even when an instruction is also waiting. On the next cycle `upc_o` equals 256 + 8 × (2 × `host_addr` + `host_wr`).
- R4: While running, a word that has no branch bit taken, no stall and no end bit is followed by the word at `upc_o` + 1.
- R5: When bit 17 of the current word is set and `mem_busy` is 1, the address holds and the same word is driven again on the next cycle.
- R6: `fetch_o` is 1 while running with bit 24 of the current word set, except in a cycle that stalls under R5.
- R7: Bit 36 of the current word is an unconditional branch. The next address is {bits 23..19, bits 11..8} of that word, with bits 11..8 as the low four bits.
- R8: Bit 37 is a branch to the same target that is taken only when `delay_en` is 1. Otherwise the sequence continues at the next address.
- R9: A word with bit 35 set loads `toggle_in` into a held flag. Bit 38 is a branch to the R7 target that is taken only when the held flag is 1.
- R10: `text_inc` is bit 20 of the current word while running. It is forced to 0 when `null_char` is 1, and on any word with bit 36, 37 or 38 set, because bit 20 is then a branch-target bit.
- R11: A word with bit 39 set and no stall ends the routine. On the next cycle the block is idle, `ctrl_word` is 0 and `upc_o` keeps the address of the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | A display instruction is waiting |
| instr_opcode | input | 4 | Opcode field of the waiting instruction |
| instr_ack | output | 1 | Instruction accepted this cycle |
| host_req | input | 1 | Host register access pending (level, held until acknowledged) |
| host_wr | input | 1 | Host access is a write |
| host_addr | input | 4 | Host register address |
| host_ack | output | 1 | Host access accepted this cycle |
| mem_busy | input | 1 | Memory interface busy |
| delay_en | input | 1 | Condition for the bit-37 branch |
| null_char | input | 1 | Character generator reports a null character |
| toggle_in | input | 1 | Ramp generator toggle state |
| ctrl_word | output | 40 | Current control word, 0 when idle |
| fetch_o | output | 1 | Fetch request strobe |
| text_inc | output | 1 | Text increment control |
| upc_o | output | 9 | Current microprogram address |

## Verification
A host register access and a display instruction can be pending in the same idle cycle. The bench raises both together. It checks that only `host_ack` is asserted and that the host routine's start address appears. It then holds the instruction until the host routine has ended, and checks that the instruction is taken in the following idle cycle. A second collision places a memory stall on an end-of-routine word that also requests a fetch. In that case both the fetch and the return to idle must wait until `mem_busy` falls.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int IMG_AW    = 9;
    localparam int IMG_UW    = 40;
    localparam int IMG_DEPTH = 1 << IMG_AW;

    // microword field positions
    localparam int B_BUSY   = 17;
    localparam int B_TINC   = 20;
    localparam int B_FETCH  = 24;
    localparam int B_SAMPLE = 35;
    localparam int B_JMP    = 36;
    localparam int B_JDLY   = 37;
    localparam int B_JTOG   = 38;
    localparam int B_END    = 39;
    localparam int TGT_LO_B = 8;
    localparam int TGT_LO_W = 4;
    localparam int TGT_HI_B = 19;
    localparam int TGT_HI_W = 5;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

    typedef logic [IMG_DEPTH-1:0][IMG_UW-1:0] image_t;

    // default image: every word ends its routine at once
    function automatic image_t default_image();
        image_t img;
        for (int i = 0; i < IMG_DEPTH; i++) begin
            img[i]         = '0;
            img[i][B_END]  = 1'b1;
        end
        return img;
    endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int AW = 9,
    parameter int UW = 40,
    parameter logic [(2**AW)-1:0][UW-1:0] IMAGE = '0
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    output logic [UW-1:0] rd_word
);

    always_ff @(posedge clk) begin
        rd_word <= IMAGE[rd_addr];
    end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
    parameter int AW         = 9,
    parameter int OPW        = 4,
    parameter int RAW        = 4,
    parameter int OP_BASE    = 0,
    parameter int OP_STRIDE  = 16,
    parameter int REG_BASE   = 256,
    parameter int REG_STRIDE = 8
) (
    input  logic [OPW-1:0] opcode,
    input  logic [RAW-1:0] reg_addr,
    input  logic           reg_wr,
    output logic [AW-1:0]  op_start,
    output logic [AW-1:0]  reg_start
);

    localparam int SLOT_W = RAW + 1;

    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot      = {reg_addr, reg_wr};
        op_start  = AW'(OP_BASE + int'(opcode) * OP_STRIDE);
        reg_start = AW'(REG_BASE + int'(slot) * REG_STRIDE);
    end

endmodule

// File: rtl/useq_next.sv
module useq_next #(
    parameter int AW   = 9,
    parameter int LO_W = 4
) (
    input  logic               run,
    input  logic [AW-1:0]      upc,
    input  logic               busy_en,
    input  logic               end_bit,
    input  logic               jmp,
    input  logic               jdly,
    input  logic               jtog,
    input  logic [LO_W-1:0]    tgt_lo,
    input  logic [AW-LO_W-1:0] tgt_hi,
    input  logic               mem_busy,
    input  logic               delay_en,
    input  logic               tog_flag,
    output logic               stall,
    output logic               done,
    output logic               jump_word,
    output logic [AW-1:0]      run_addr
);

    logic taken;

    always_comb begin
        stall     = run & busy_en & mem_busy;
        done      = run & end_bit & ~stall;
        jump_word = jmp | jdly | jtog;
        taken     = jmp | (jdly & delay_en) | (jtog & tog_flag);
        run_addr  = taken ? {tgt_hi, tgt_lo} : upc + AW'(1);
    end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import useq_pkg::*;
#(
    parameter int AW         = IMG_AW,
    parameter int UW         = IMG_UW,
    parameter int OPW        = 4,
    parameter int RAW        = 4,
    parameter int OP_BASE    = 0,
    parameter int OP_STRIDE  = 16,
    parameter int REG_BASE   = 256,
    parameter int REG_STRIDE = 8,
    parameter logic [(2**AW)-1:0][UW-1:0] INIT = default_image()
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           instr_valid,
    input  logic [OPW-1:0] instr_opcode,
    output logic           instr_ack,
    input  logic           host_req,
    input  logic           host_wr,
    input  logic [RAW-1:0] host_addr,
    output logic           host_ack,
    input  logic           mem_busy,
    input  logic           delay_en,
    input  logic           null_char,
    input  logic           toggle_in,
    output logic [UW-1:0]  ctrl_word,
    output logic           fetch_o,
    output logic           text_inc,
    output logic [AW-1:0]  upc_o
);

    localparam int HI_W = AW - TGT_LO_W;

    sq_state_e     state, state_n;
    logic [AW-1:0] upc, nxt;
    logic [UW-1:0] uword;
    logic [AW-1:0] op_start, reg_start, run_addr;
    logic          stall, done, jump_word;
    logic          tog_flag;
    logic          running;

    assign running = (state == SQ_RUN);
    assign upc_o   = upc;

    useq_dispatch #(
        .AW(AW), .OPW(OPW), .RAW(RAW),
        .OP_BASE(OP_BASE), .OP_STRIDE(OP_STRIDE),
        .REG_BASE(REG_BASE), .REG_STRIDE(REG_STRIDE)
    ) u_disp (
        .opcode   (instr_opcode),
        .reg_addr (host_addr),
        .reg_wr   (host_wr),
        .op_start (op_start),
        .reg_start(reg_start)
    );

    useq_next #(.AW(AW), .LO_W(TGT_LO_W)) u_next (
        .run      (running),
        .upc      (upc),
        .busy_en  (uword[B_BUSY]),
        .end_bit  (uword[B_END]),
        .jmp      (uword[B_JMP]),
        .jdly     (uword[B_JDLY]),
        .jtog     (uword[B_JTOG]),
        .tgt_lo   (uword[TGT_LO_B +: TGT_LO_W]),
        .tgt_hi   (uword[TGT_HI_B +: HI_W]),
        .mem_busy (mem_busy),
        .delay_en (delay_en),
        .tog_flag (tog_flag),
        .stall    (stall),
        .done     (done),
        .jump_word(jump_word),
        .run_addr (run_addr)
    );

    // ROM read follows the selected next address
    useq_store #(.AW(AW), .UW(UW), .IMAGE(INIT)) u_store (
        .clk    (clk),
        .rd_addr(nxt),
        .rd_word(uword)
    );

    // next state, next address and dispatch handshakes
    always_comb begin
        state_n   = state;
        nxt       = upc;
        host_ack  = 1'b0;
        instr_ack = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (host_req) begin
                    host_ack = 1'b1;
                    nxt      = reg_start;
                    state_n  = SQ_RUN;
                end else if (instr_valid) begin
                    instr_ack = 1'b1;
                    nxt       = op_start;
                    state_n   = SQ_RUN;
                end
            end
            SQ_RUN: begin
                if (stall) begin
                    nxt = upc;
                end else if (done) begin
                    state_n = SQ_IDLE;
                end else begin
                    nxt = run_addr;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            upc      <= '0;
            tog_flag <= 1'b0;
        end else begin
            state <= state_n;
            upc   <= nxt;
            if (running && !stall && uword[B_SAMPLE]) begin
                tog_flag <= toggle_in;
            end
        end
    end

    // outputs
    always_comb begin
        ctrl_word = '0;
        fetch_o   = 1'b0;
        text_inc  = 1'b0;
        if (running) begin
            ctrl_word = uword;
            fetch_o   = uword[B_FETCH] & ~stall;
            text_inc  = uword[B_TINC] & ~jump_word & ~null_char;
        end
    end

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
    parameter int AW = 9,
    parameter int UW = 40
) (
    input logic          clk,
    input logic          rst,
    input logic          running,
    input logic          instr_ack,
    input logic          host_ack,
    input logic          mem_busy,
    input logic          null_char,
    input logic [UW-1:0] ctrl_word,
    input logic          fetch_o,
    input logic          text_inc,
    input logic [AW-1:0] upc_o
);

    logic stalled;
    assign stalled = running && ctrl_word[17] && mem_busy;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> (ctrl_word == '0) && !fetch_o && !text_inc); // R1

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (instr_ack || host_ack) |-> !running); // R2

    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (rst)
        !(host_ack && instr_ack)); // R3

    AST_DISPATCH_RUN: assert property (@(posedge clk) disable iff (rst)
        (host_ack || instr_ack) |=> running); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && !stalled && !ctrl_word[39] && (ctrl_word[38:36] == 3'b000))
        |=> upc_o == AW'($past(upc_o) + AW'(1))); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stalled |=> running && $stable(upc_o) && $stable(ctrl_word)); // R5

    AST_NO_FETCH_STALL: assert property (@(posedge clk) disable iff (rst)
        stalled |-> !fetch_o); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (running && !stalled && !ctrl_word[39] && ctrl_word[36])
        |=> upc_o == {$past(ctrl_word[23:19]), $past(ctrl_word[11:8])}); // R7

    AST_NULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        null_char |-> !text_inc); // R10

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (running && !stalled && ctrl_word[39])
        |=> !running && $stable(upc_o)); // R11

endmodule

bind ucode_sequencer useq_checker #(.AW(AW), .UW(UW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .running  (running),
    .instr_ack(instr_ack),
    .host_ack (host_ack),
    .mem_busy (mem_busy),
    .null_char(null_char),
    .ctrl_word(ctrl_word),
    .fetch_o  (fetch_o),
    .text_inc (text_inc),
    .upc_o    (upc_o)
);

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;

    typedef logic [511:0][39:0] img_t;

    function automatic img_t build_prog();
        img_t p;
        p = '0;
        // opcode 1 at 16: fetch, busy-enabled, text increment, end
        p[16][24] = 1'b1;
        p[17][17] = 1'b1;
        p[18][20] = 1'b1;
        p[19][39] = 1'b1;
        // opcode 2 at 32: unconditional branch to 40 (bit 20 set by target)
        p[32][36] = 1'b1; p[32][11:8] = 4'h8; p[32][23:19] = 5'h02;
        p[40][39] = 1'b1; p[40][0] = 1'b1;
        // opcode 3 at 48: delay-enabled branch to 56
        p[48][37] = 1'b1; p[48][11:8] = 4'h8; p[48][23:19] = 5'h03;
        p[49][39] = 1'b1; p[49][1] = 1'b1;
        p[56][39] = 1'b1; p[56][2] = 1'b1;
        // opcode 4 at 64: sample toggle, then flag branch to 72
        p[64][35] = 1'b1;
        p[65][38] = 1'b1; p[65][11:8] = 4'h8; p[65][23:19] = 5'h04;
        p[66][39] = 1'b1; p[66][5] = 1'b1;
        p[72][39] = 1'b1; p[72][6] = 1'b1;
        // opcode 5 at 80: end + busy enable + fetch on one word
        p[80][39] = 1'b1; p[80][17] = 1'b1; p[80][24] = 1'b1;
        // host read reg 2 at 288, host write reg 2 at 296
        p[288][39] = 1'b1; p[288][3] = 1'b1;
        p[296][39] = 1'b1; p[296][4] = 1'b1;
        return p;
    endfunction

    localparam img_t PROG = build_prog();

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [3:0]  instr_opcode;
    logic        instr_ack;
    logic        host_req, host_wr;
    logic [3:0]  host_addr;
    logic        host_ack;
    logic        mem_busy, delay_en, null_char, toggle_in;
    logic [39:0] ctrl_word;
    logic        fetch_o, text_inc;
    logic [8:0]  upc_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ucode_sequencer #(.INIT(PROG)) dut (
        .clk(clk), .rst(rst),
        .instr_valid(instr_valid), .instr_opcode(instr_opcode), .instr_ack(instr_ack),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_ack(host_ack),
        .mem_busy(mem_busy), .delay_en(delay_en), .null_char(null_char), .toggle_in(toggle_in),
        .ctrl_word(ctrl_word), .fetch_o(fetch_o), .text_inc(text_inc), .upc_o(upc_o)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_op(input logic [3:0] op);
        instr_opcode = op;
        instr_valid  = 1'b1;
        #1;
        check("R2 instr_ack in idle", 64'(instr_ack), 64'd1);
        step();
        instr_valid = 1'b0;
        check("R2 start address", 64'(upc_o), 64'(16 * op));
        check("R2 start word", 64'(ctrl_word), 64'(PROG[16 * op]));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        instr_valid = 0; instr_opcode = 0; host_req = 0; host_wr = 0; host_addr = 0;
        mem_busy = 0; delay_en = 0; null_char = 0; toggle_in = 0;
        step(); step();
        rst = 1'b0;
        #1;
        check("R1 upc after reset", 64'(upc_o), 64'd0);
        check("R1 ctrl after reset", 64'(ctrl_word), 64'd0);
        check("R1 strobes after reset", 64'({fetch_o, text_inc, instr_ack, host_ack}), 64'd0);
    endtask

    task automatic t_linear();
        start_op(4'd1);
        check("R6 fetch on bit 24", 64'(fetch_o), 64'd1);
        step();
        check("R4 step to 17", 64'(upc_o), 64'd17);
        check("R6 no fetch on 17", 64'(fetch_o), 64'd0);
        mem_busy = 1'b1;
        step();
        check("R5 hold while busy", 64'(upc_o), 64'd17);
        check("R5 word re-issued", 64'(ctrl_word), 64'(PROG[17]));
        mem_busy = 1'b0;
        step();
        check("R4 step to 18", 64'(upc_o), 64'd18);
        check("R10 text_inc on bit 20", 64'(text_inc), 64'd1);
        null_char = 1'b1;
        #1;
        check("R10 null_char blocks", 64'(text_inc), 64'd0);
        null_char = 1'b0;
        step();
        check("R4 step to 19", 64'(upc_o), 64'd19);
        step();
        check("R11 idle ctrl", 64'(ctrl_word), 64'd0);
        check("R11 upc kept", 64'(upc_o), 64'd19);
    endtask

    task automatic t_jump();
        start_op(4'd2);
        check("R10 no text_inc on branch word", 64'(text_inc), 64'd0);
        step();
        check("R7 branch target", 64'(upc_o), 64'd40);
        check("R7 target word", 64'(ctrl_word), 64'(PROG[40]));
        step();
        check("R11 idle after 40", 64'(ctrl_word), 64'd0);
    endtask

    task automatic t_cond();
        delay_en = 1'b0;
        start_op(4'd3);
        step();
        check("R8 fall through", 64'(upc_o), 64'd49);
        step();
        delay_en = 1'b1;
        start_op(4'd3);
        step();
        check("R8 taken", 64'(upc_o), 64'd56);
        check("R8 taken word", 64'(ctrl_word), 64'(PROG[56]));
        delay_en = 1'b0;
        step();
    endtask

    task automatic t_toggle();
        toggle_in = 1'b1;
        start_op(4'd4);
        step();
        toggle_in = 1'b0;
        check("R9 step to 65", 64'(upc_o), 64'd65);
        step();
        check("R9 held flag branch", 64'(upc_o), 64'd72);
        step();
        start_op(4'd4);
        step();
        toggle_in = 1'b1;
        step();
        check("R9 cleared flag falls through", 64'(upc_o), 64'd66);
        toggle_in = 1'b0;
        step();
    endtask

    task automatic t_priority();
        host_req = 1'b1; host_wr = 1'b0; host_addr = 4'd2;
        instr_opcode = 4'd2; instr_valid = 1'b1;
        #1;
        check("R3 host_ack", 64'(host_ack), 64'd1);
        check("R3 instr_ack held off", 64'(instr_ack), 64'd0);
        step();
        host_req = 1'b0;
        check("R3 host read start", 64'(upc_o), 64'd288);
        check("R3 no ack while running", 64'(instr_ack), 64'd0);
        step();
        check("R11 idle after host routine", 64'(ctrl_word), 64'd0);
        check("R2 waiting instr taken", 64'(instr_ack), 64'd1);
        step();
        instr_valid = 1'b0;
        check("R2 instr after host", 64'(upc_o), 64'd32);
        step(); step();
        host_req = 1'b1; host_wr = 1'b1; host_addr = 4'd2;
        #1;
        check("R3 host write ack", 64'(host_ack), 64'd1);
        step();
        host_req = 1'b0;
        check("R3 host write start", 64'(upc_o), 64'd296);
        step();
    endtask

    task automatic t_stall_end();
        start_op(4'd5);
        mem_busy = 1'b1;
        #1;
        check("R6 fetch withheld in stall", 64'(fetch_o), 64'd0);
        step();
        check("R5 end word held", 64'(upc_o), 64'd80);
        check("R5 end word still driven", 64'(ctrl_word), 64'(PROG[80]));
        mem_busy = 1'b0;
        #1;
        check("R6 fetch after busy clears", 64'(fetch_o), 64'd1);
        step();
        check("R11 idle after stalled end", 64'(ctrl_word), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_linear();
        t_jump();
        t_cond();
        t_toggle();
        t_priority();
        t_stall_end();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule